// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block fetches a missing address translation from memory. When the TLB reports a miss, it is given the page number of the logical address and the privilege mode of the access. It then makes two dependent word reads. The first read fetches a segment-table entry. The second read fetches a page-table entry. The physical frame that results is written into the TLB. The logical address is 32 bits wide. Its upper ten bits select a segment-table entry, the next ten bits select a page-table entry, and the low twelve bits are a byte offset that the walk never uses.

Two base registers locate the segment tables. One serves supervisor accesses and one serves user accesses. Each base register holds only the upper 20 bits of the table address. Entry addresses are formed by joining bit fields together, not by adding, so the address path contains no adder. Each write to a base register sends a one-cycle purge strobe to the TLB. Memory is reached through a request/acknowledge read port. The TLB is reached through a single-cycle write strobe.

Top module: `tw_walker`

## Requirements
- R1: After reset, busy, mem_req, tlb_wr and tlb_purge are all 0, and both base registers hold 0.
- R2: A cycle with rp_wr_en=1 loads rp_wr_data into the supervisor base register when rp_wr_sup=1, and into the user base register when rp_wr_sup=0.
- R3: Each cycle with rp_wr_en=1 makes tlb_purge high for exactly the next cycle. tlb_purge is never high otherwise.
- R4: A walk is accepted only in a cycle where miss_valid=1 and busy=0. busy is 1 in the following cycle. A miss_valid that arrives while busy=1 is ignored and produces no second TLB write.
- R5: The first read address is {base, miss_vpn[19:10], 2'b00}. The base comes from the supervisor register when miss_sup=1 and from the user register when miss_sup=0, sampled in the cycle of acceptance.
- R6: The second read address is {segment word[31:12], miss_vpn[9:0], 2'b00}. The low 12 bits of the segment word have no effect on it.
- R7: mem_req stays high, and mem_addr stays stable, in every cycle after a request cycle in which mem_ack was 0.
- R8: The cycle after the second acknowledge, tlb_wr is 1 for one cycle. In that cycle tlb_sup is the accepted mode, tlb_vpn is the accepted page number, tlb_pfn is page word[31:12] and tlb_flags is page word[11:0].
- R9: busy stays 1 from the cycle after acceptance through the tlb_wr cycle, and is 0 in the cycle after tlb_wr.
- R10: A base-register write during a walk does not alter the addresses of that walk. The next walk uses the new value.
- R11: mem_ack while no request is pending is ignored: busy, mem_req and tlb_wr stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rp_wr_en | input | 1 | Base register write strobe |
| rp_wr_sup | input | 1 | Write target: 1 supervisor, 0 user |
| rp_wr_data | input | 20 | Upper bits of segment-table address |
| miss_valid | input | 1 | TLB miss, start a walk |
| miss_sup | input | 1 | Mode of the missing access: 1 supervisor |
| miss_vpn | input | 20 | Logical page number (address bits 31:12) |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_ack | input | 1 | Read data valid this cycle |
| mem_rdata | input | 32 | Read data |
| tlb_wr | output | 1 | TLB write strobe |
| tlb_sup | output | 1 | Mode of the written translation |
| tlb_vpn | output | 20 | Logical page number written |
| tlb_pfn | output | 20 | Physical frame written |
| tlb_flags | output | 12 | Low bits of the page entry, passed through |
| tlb_purge | output | 1 | Purge-all strobe to the TLB |

## Verification
The timing of each result is fixed, and the checks follow it. busy rises one cycle after a miss is accepted. The next address is on mem_addr one cycle after each acknowledge. tlb_wr follows the second acknowledge by one cycle, busy falls one cycle after tlb_wr, and tlb_purge follows a base write by one cycle. All inputs are driven on the falling edge, and all outputs are compared on the next falling edge, so each check looks exactly one register stage after its cause.

The memory responder adds a chosen number of wait cycles (0 to 5) before each acknowledge. On every acknowledge it checks mem_addr against an address queue built in advance from the requirements. A monitor pops expected TLB writes from a second queue whenever tlb_wr is high.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int TW_VA_W  = 32;
  localparam int TW_SEG_W = 10;
  localparam int TW_PG_W  = 10;
  localparam int TW_ENT_LG = 2;

  typedef enum logic [2:0] {
    TW_IDLE      = 3'd0,
    TW_SEG_REQ   = 3'd1,
    TW_SEG_WAIT  = 3'd2,
    TW_PAGE_REQ  = 3'd3,
    TW_PAGE_WAIT = 3'd4,
    TW_DONE      = 3'd5
  } tw_state_e;
endpackage

// File: rtl/tw_root_bank.sv
module tw_root_bank #(
  parameter int ROOT_W = 20,
  parameter int NMODE  = 2,
  localparam int SEL_W = (NMODE > 1) ? $clog2(NMODE) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [ROOT_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [ROOT_W-1:0] rd_root,
  output logic              purge
);
  logic [NMODE-1:0][ROOT_W-1:0] root_vec;

  // one base register per privilege mode
  for (genvar g = 0; g < NMODE; g++) begin : g_root
    logic [ROOT_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        q <= '0;
      else if (wr_en && (wr_sel == SEL_W'(g)))
        q <= wr_data;
    end
    assign root_vec[g] = q;
  end

  assign rd_root = root_vec[rd_sel];

  // any base change invalidates every cached translation
  always_ff @(posedge clk) begin
    if (!rst_n) purge <= 1'b0;
    else        purge <= wr_en;
  end
endmodule

// File: rtl/tw_seq.sv
module tw_seq
  import tw_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_req,
  input  logic      mem_ack,
  output tw_state_e state,
  output logic      walk_start,
  output logic      seg_done,
  output logic      page_done,
  output logic      mem_req,
  output logic      tlb_wr,
  output logic      busy
);
  tw_state_e nxt;
  logic in_seg, in_page;

  assign in_seg  = (state == TW_SEG_REQ)  || (state == TW_SEG_WAIT);
  assign in_page = (state == TW_PAGE_REQ) || (state == TW_PAGE_WAIT);

  assign walk_start = (state == TW_IDLE) && start_req;
  assign seg_done   = in_seg  && mem_ack;
  assign page_done  = in_page && mem_ack;
  assign mem_req    = in_seg || in_page;
  assign tlb_wr     = (state == TW_DONE);
  assign busy       = (state != TW_IDLE);

  always_comb begin
    nxt = state;
    unique case (state)
      TW_IDLE:      if (start_req) nxt = TW_SEG_REQ;
      TW_SEG_REQ:   nxt = mem_ack ? TW_PAGE_REQ : TW_SEG_WAIT;
      TW_SEG_WAIT:  if (mem_ack) nxt = TW_PAGE_REQ;
      TW_PAGE_REQ:  nxt = mem_ack ? TW_DONE : TW_PAGE_WAIT;
      TW_PAGE_WAIT: if (mem_ack) nxt = TW_DONE;
      TW_DONE:      nxt = TW_IDLE;
      default:      nxt = TW_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= TW_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/tw_addr_path.sv
module tw_addr_path #(
  parameter int VA_W   = 32,
  parameter int SEG_W  = 10,
  parameter int PG_W   = 10,
  parameter int ENT_LG = 2,
  localparam int VPN_W  = SEG_W + PG_W,
  localparam int OFF_W  = VA_W - VPN_W,
  localparam int ROOT_W = VA_W - SEG_W - ENT_LG,
  localparam int PTB_W  = VA_W - PG_W - ENT_LG,
  localparam int PFN_W  = VA_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              walk_start,
  input  logic              seg_done,
  input  logic              page_done,
  input  logic [ROOT_W-1:0] root,
  input  logic              miss_sup,
  input  logic [VPN_W-1:0]  miss_vpn,
  input  logic [VA_W-1:0]   rdata,
  output logic [VA_W-1:0]   addr,
  output logic              sup,
  output logic [VPN_W-1:0]  vpn,
  output logic [PFN_W-1:0]  pfn,
  output logic [OFF_W-1:0]  flags
);
  // segment entry: base bits on top, segment index, zero entry offset
  function automatic logic [VA_W-1:0] seg_entry_addr(
    input logic [ROOT_W-1:0] b, input logic [VPN_W-1:0] p);
    return {b, p[VPN_W-1 -: SEG_W], {ENT_LG{1'b0}}};
  endfunction

  // page entry: upper bits of segment word, page index, zero entry offset
  function automatic logic [VA_W-1:0] page_entry_addr(
    input logic [VA_W-1:0] sw, input logic [VPN_W-1:0] p);
    return {sw[VA_W-1 -: PTB_W], p[PG_W-1:0], {ENT_LG{1'b0}}};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr  <= '0;
      sup   <= 1'b0;
      vpn   <= '0;
      pfn   <= '0;
      flags <= '0;
    end else begin
      if (walk_start) begin
        addr <= seg_entry_addr(root, miss_vpn);
        sup  <= miss_sup;
        vpn  <= miss_vpn;
      end
      if (seg_done)
        addr <= page_entry_addr(rdata, vpn);
      if (page_done) begin
        pfn   <= rdata[VA_W-1 -: PFN_W];
        flags <= rdata[OFF_W-1:0];
      end
    end
  end
endmodule

// File: rtl/tw_walker.sv
module tw_walker
  import tw_pkg::*;
#(
  parameter int VA_W   = TW_VA_W,
  parameter int SEG_W  = TW_SEG_W,
  parameter int PG_W   = TW_PG_W,
  parameter int ENT_LG = TW_ENT_LG,
  localparam int VPN_W  = SEG_W + PG_W,
  localparam int OFF_W  = VA_W - VPN_W,
  localparam int ROOT_W = VA_W - SEG_W - ENT_LG,
  localparam int PFN_W  = VA_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rp_wr_en,
  input  logic              rp_wr_sup,
  input  logic [ROOT_W-1:0] rp_wr_data,
  input  logic              miss_valid,
  input  logic              miss_sup,
  input  logic [VPN_W-1:0]  miss_vpn,
  output logic              busy,
  output logic              mem_req,
  output logic [VA_W-1:0]   mem_addr,
  input  logic              mem_ack,
  input  logic [VA_W-1:0]   mem_rdata,
  output logic              tlb_wr,
  output logic              tlb_sup,
  output logic [VPN_W-1:0]  tlb_vpn,
  output logic [PFN_W-1:0]  tlb_pfn,
  output logic [OFF_W-1:0]  tlb_flags,
  output logic              tlb_purge
);
  tw_state_e         state;
  logic              walk_start, seg_done, page_done;
  logic [ROOT_W-1:0] sel_root;

  tw_root_bank #(.ROOT_W(ROOT_W), .NMODE(2)) u_roots (
    .clk(clk), .rst_n(rst_n),
    .wr_en(rp_wr_en), .wr_sel(rp_wr_sup), .wr_data(rp_wr_data),
    .rd_sel(miss_sup), .rd_root(sel_root), .purge(tlb_purge)
  );

  tw_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start_req(miss_valid), .mem_ack(mem_ack),
    .state(state), .walk_start(walk_start), .seg_done(seg_done),
    .page_done(page_done), .mem_req(mem_req), .tlb_wr(tlb_wr), .busy(busy)
  );

  tw_addr_path #(.VA_W(VA_W), .SEG_W(SEG_W), .PG_W(PG_W), .ENT_LG(ENT_LG)) u_path (
    .clk(clk), .rst_n(rst_n),
    .walk_start(walk_start), .seg_done(seg_done), .page_done(page_done),
    .root(sel_root), .miss_sup(miss_sup), .miss_vpn(miss_vpn),
    .rdata(mem_rdata), .addr(mem_addr),
    .sup(tlb_sup), .vpn(tlb_vpn), .pfn(tlb_pfn), .flags(tlb_flags)
  );
endmodule

// File: rtl/tw_walker_chk.sv
module tw_walker_chk #(
  parameter int VA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            mem_req,
  input logic            mem_ack,
  input logic [VA_W-1:0] mem_addr,
  input logic            tlb_wr,
  input logic            tlb_purge,
  input logic            rp_wr_en,
  input logic            walk_start,
  input logic            seg_done,
  input logic            page_done
);
  // R3
  purge_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rp_wr_en |=> tlb_purge);
  // R3
  purge_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_purge |-> $past(rp_wr_en));
  // R4
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_start |=> (busy && mem_req));
  // R6
  seg_then_page_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_done |=> mem_req);
  // R7
  req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
  // R8
  page_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    page_done |=> tlb_wr);
  // R8
  write_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_wr |=> !tlb_wr);
  // R9
  idle_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_wr |=> !busy);
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !tlb_wr));
endmodule

bind tw_walker tw_walker_chk #(.VA_W(VA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .tlb_wr(tlb_wr), .tlb_purge(tlb_purge),
  .rp_wr_en(rp_wr_en), .walk_start(walk_start), .seg_done(seg_done),
  .page_done(page_done)
);

// File: tb/tw_walker_test.sv
module tw_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rp_wr_en = 1'b0, rp_wr_sup = 1'b0;
  logic [19:0] rp_wr_data = '0;
  logic        miss_valid = 1'b0, miss_sup = 1'b0;
  logic [19:0] miss_vpn = '0;
  logic        busy, mem_req, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic        tlb_wr, tlb_sup, tlb_purge;
  logic [19:0] tlb_vpn, tlb_pfn;
  logic [11:0] tlb_flags;

  int total = 0, bad = 0;
  int lat = 0, wcnt = 0;
  logic stray = 1'b0, chk_idle = 1'b0;
  logic prev_wait = 1'b0;
  logic [31:0] prev_addr = '0;
  logic [19:0] root_m [2];
  logic [31:0] addr_q [$];
  logic [52:0] tlb_q [$];

  always #10 clk = ~clk;

  tw_walker uut (.*);

  function automatic logic [31:0] memfn(input logic [31:0] a);
    return {a[21:2] ^ 20'h5C3A9 ^ {a[31:22], a[31:22]}, a[13:2] ^ 12'hA6D};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory responder and scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (chk_idle) begin
        check(!busy, "R9 busy low after tlb_wr", 64'(busy), 64'd0);
        chk_idle = 1'b0;
      end
      if (prev_wait && mem_req)
        check(mem_addr == prev_addr, "R7 address held", 64'(mem_addr), 64'(prev_addr));
      if (tlb_wr) begin
        if (tlb_q.size() == 0)
          check(1'b0, "R4 unexpected tlb_wr", 64'(tlb_vpn), 64'd0);
        else begin
          logic [52:0] e;
          e = tlb_q.pop_front();
          check({tlb_sup, tlb_vpn, tlb_pfn, tlb_flags} == e, "R8 tlb entry",
                64'({tlb_sup, tlb_vpn, tlb_pfn, tlb_flags}), 64'(e));
        end
        chk_idle = 1'b1;
      end
    end
    if (mem_req && wcnt >= lat) begin
      mem_ack = 1'b1;
      mem_rdata = memfn(mem_addr);
      if (addr_q.size() == 0)
        check(1'b0, "R5 R6 unexpected read", 64'(mem_addr), 64'd0);
      else begin
        logic [31:0] ea;
        ea = addr_q.pop_front();
        check(mem_addr == ea, "R5 R6 read address", 64'(mem_addr), 64'(ea));
      end
      wcnt = 0;
      prev_wait = 1'b0;
    end else begin
      mem_ack = mem_req ? 1'b0 : stray;
      mem_rdata = stray ? 32'hFFFF_FFFF : 32'h0;
      wcnt = mem_req ? wcnt + 1 : 0;
      prev_wait = mem_req;
      prev_addr = mem_addr;
    end
  end

  task automatic write_root(input logic sup, input logic [19:0] v);
    rp_wr_en = 1'b1; rp_wr_sup = sup; rp_wr_data = v;
    @(negedge clk);
    rp_wr_en = 1'b0;
    root_m[sup] = v;
    check(tlb_purge == 1'b1, "R3 purge pulse", 64'(tlb_purge), 64'd1);
    @(negedge clk);
    check(tlb_purge == 1'b0, "R3 purge single", 64'(tlb_purge), 64'd0);
  endtask

  // driver: computes expected reads and TLB entry, then starts the walk
  task automatic run_walk(input logic [19:0] vpn, input logic sup, input int l,
                          input bit poke, input bit do_rp, input logic [19:0] rpv);
    logic [31:0] sa, sw, pa, pw;
    sa = {root_m[sup], vpn[19:10], 2'b00};
    sw = memfn(sa);
    pa = {sw[31:12], vpn[9:0], 2'b00};
    pw = memfn(pa);
    addr_q.push_back(sa);
    addr_q.push_back(pa);
    tlb_q.push_back({sup, vpn, pw[31:12], pw[11:0]});
    lat = l;
    miss_valid = 1'b1; miss_sup = sup; miss_vpn = vpn;
    @(negedge clk);
    miss_valid = 1'b0;
    check(busy == 1'b1, "R4 R9 busy after accept", 64'(busy), 64'd1);
    if (poke) begin
      miss_valid = 1'b1; miss_vpn = ~vpn; miss_sup = ~sup;
      @(negedge clk);
      miss_valid = 1'b0;
    end
    if (do_rp) write_root(sup, rpv); // R10 change mid-walk
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    root_m[0] = '0; root_m[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(!busy && !mem_req && !tlb_wr && !tlb_purge, "R1 reset outputs",
          64'({busy, mem_req, tlb_wr, tlb_purge}), 64'd0);
    run_walk(20'h12345, 1'b0, 0, 0, 0, 0);   // R1 zero base registers
    write_root(1'b0, 20'hABCDE);             // R2 user
    write_root(1'b1, 20'h13579);             // R2 supervisor
    run_walk(20'h00000, 1'b0, 0, 0, 0, 0);
    run_walk(20'hFFFFF, 1'b1, 2, 0, 0, 0);   // R5 supervisor base
    run_walk(20'h3FC01, 1'b0, 5, 0, 0, 0);   // R6 R7 long waits
    run_walk(20'h80200, 1'b1, 1, 0, 0, 0);
    run_walk(20'h55AA5, 1'b0, 4, 0, 1, 20'h2468A); // R10
    run_walk(20'h55AA5, 1'b0, 0, 0, 0, 0);   // R10 new base used
    run_walk(20'h0F0F0, 1'b1, 3, 1, 0, 0);   // R4 miss while busy
    // R11 stray ack while idle
    stray = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(!busy && !mem_req && !tlb_wr, "R11 stray ack ignored",
            64'({busy, mem_req, tlb_wr}), 64'd0);
    end
    stray = 1'b0;
    @(negedge clk);
    check(tlb_q.size() == 0 && addr_q.size() == 0, "R4 R8 all results seen",
          64'(tlb_q.size() + addr_q.size()), 64'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule